// File: doc/BRIEF.md
# Privilege-Filtered Register Space Guard

This block stands between a simple peripheral bus and a peripheral's register storage. It decides, for every bus access, whether the register storage is allowed to see it. The register space has two parts. A fixed protected segment at the bottom of the address range holds the global control, test and interrupt words. The configuration word sits at address 0 of that segment. The rest of the range is an assignable segment for the remaining registers and tables. A single protection bit inside the configuration word makes the assignable segment either supervisor-only or open to every caller.

Supervisor accesses always reach the storage. A user access that is refused never changes any state. A refused user read returns a constant instead of register data. That constant is all zeros when the fixed segment was addressed, and all ones when the assignable segment was addressed while it is protected. The bus interface has no back-pressure. An access is presented for one cycle on the read or write strobe. It is always accepted, and it completes with a one-cycle ready pulse on the next cycle. The bus never has to wait and cannot stall the guard.

Top module: `privguard_top`

## Requirements
- R1: After reset, bus_ready and bus_rdata are 0. The configuration word (address 0) reads 16'h0080, so the protection bit (bit 7) is 1 and the assignable segment starts protected.
- R2: A supervisor access (bus_super=1) to any address passes through. A write stores its data, and a later read returns the stored value.
- R3: A user read (bus_super=0) of the fixed segment (addresses 0 to 3) returns 16'h0000, whatever the protection bit holds.
- R4: A user read of the assignable segment (addresses 4 and up) returns 16'hFFFF while the protection bit is 1.
- R5: A user write to the fixed segment, or to the assignable segment while the protection bit is 1, changes no stored word.
- R6: While the protection bit is 0, user reads and writes of the assignable segment pass through like supervisor accesses.
- R7: The configuration word belongs to the fixed segment whatever the protection bit holds. A user access to it is always refused, so a user write cannot clear the protection bit.
- R8: Each cycle with bus_rd or bus_wr high produces bus_ready=1 exactly one cycle later. A cycle with no strobe produces bus_ready=0 and bus_rdata=16'h0000 one cycle later. Read data is valid in the same cycle as bus_ready.
- R9: When bus_rd and bus_wr are both high, the access is handled as a write only, and bus_rdata is 16'h0000 with its ready pulse.
- R10: A supervisor write that changes the protection bit takes effect for an access presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word address of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_wdata | input | 16 | Write data |
| bus_super | input | 1 | 1 when the caller is in supervisor mode |
| bus_rdata | output | 16 | Read data, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse, one cycle after each access |

## Verification
Two functions can fall in the same cycle. The first is a change of the protection bit by a supervisor write to the configuration word. The second is a user access to the assignable segment that depends on that bit. The bench provokes this with back-to-back accesses: it clears or sets the bit, and in the next cycle a user read or write targets the assignable segment. A reference model, updated in access order, judges whether the result follows the new setting. The bench also raises both strobes in one cycle, where a read and a write meet. It expects write-only behaviour and zero read data, then confirms the stored word by reading it back.

// File: rtl/privguard_pkg.sv
package privguard_pkg;
  // Which part of the register space an address falls in.
  typedef enum logic [1:0] {
    SEG_CFG    = 2'd0,  // configuration word, inside the fixed segment
    SEG_FIXED  = 2'd1,  // remaining fixed supervisor-only words
    SEG_ASSIGN = 2'd2   // assignable segment
  } seg_e;
endpackage

// File: rtl/privguard_decode.sv
module privguard_decode
  import privguard_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int FIX_WORDS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              super_mode,
  input  logic              prot_bit,
  output seg_e              seg,
  output logic              permit
);
  localparam logic [ADDR_W-1:0] FIX_LIMIT = ADDR_W'(FIX_WORDS);

  always_comb begin
    if (addr == '0)            seg = SEG_CFG;
    else if (addr < FIX_LIMIT) seg = SEG_FIXED;
    else                       seg = SEG_ASSIGN;
  end

  // Supervisor always passes; user only into an open assignable segment.
  assign permit = super_mode || ((seg == SEG_ASSIGN) && !prot_bit);
endmodule

// File: rtl/privguard_cfg.sv
module privguard_cfg #(
  parameter int DATA_W   = 16,
  parameter int PROT_POS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              prot_bit
);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << PROT_POS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (we) q <= wdata;
  end

  assign prot_bit = q[PROT_POS];
endmodule

// File: rtl/privguard_regfile.sv
module privguard_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/privguard_top.sv
module privguard_top
  import privguard_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int FIX_WORDS = 4,
  parameter int PROT_POS  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_super,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready
);
  localparam logic [DATA_W-1:0] FIXED_DENY  = '0;
  localparam logic [DATA_W-1:0] ASSIGN_DENY = '1;

  seg_e              seg;
  logic              permit;
  logic              prot_bit;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] mem_q;
  logic              cfg_we;
  logic              mem_we;
  logic              rd_only;
  logic [DATA_W-1:0] rd_next;

  privguard_decode #(.ADDR_W(ADDR_W), .FIX_WORDS(FIX_WORDS)) u_decode (
    .addr(bus_addr), .super_mode(bus_super), .prot_bit(prot_bit),
    .seg(seg), .permit(permit)
  );

  assign cfg_we = bus_wr && permit && (seg == SEG_CFG);
  assign mem_we = bus_wr && permit && (seg != SEG_CFG);

  privguard_cfg #(.DATA_W(DATA_W), .PROT_POS(PROT_POS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(bus_wdata),
    .q(cfg_q), .prot_bit(prot_bit)
  );

  privguard_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(mem_q)
  );

  // A write strobe wins over a simultaneous read strobe.
  assign rd_only = bus_rd && !bus_wr;

  always_comb begin
    rd_next = '0;
    if (rd_only) begin
      if (permit)                 rd_next = (seg == SEG_CFG) ? cfg_q : mem_q;
      else if (seg == SEG_ASSIGN) rd_next = ASSIGN_DENY;
      else                        rd_next = FIXED_DENY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_rd || bus_wr;
      bus_rdata <= rd_next;
    end
  end

  // R8: one ready pulse per strobe cycle, nothing otherwise
  assert_ready_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> bus_ready);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> (!bus_ready && bus_rdata == '0));

  // R3: user read of the fixed segment yields zeros
  assert_fixed_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && !bus_super && bus_addr < ADDR_W'(FIX_WORDS)) |=> bus_rdata == '0);

  // R4: user read of protected assignable segment yields ones
  assert_assign_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && !bus_super && bus_addr >= ADDR_W'(FIX_WORDS) && prot_bit)
    |=> bus_rdata == '1);

  // R7: configuration word cannot be changed from user mode
  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_super && bus_addr == '0) |=> $stable(cfg_q));

  // R9: both strobes together return zero data
  assert_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> bus_rdata == '0);
endmodule

// File: tb/privguard_top_tb.sv
module privguard_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_super = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_ready;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] m_mem [64];
  logic [15:0] m_cfg;

  always #5 clk = ~clk;

  privguard_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_super(bus_super),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives one access, samples at the next falling edge.
  task automatic do_access(input bit rd, input bit wr, input bit sup,
                           input logic [5:0] a, input logic [15:0] d, input string tag);
    bit fixed;
    bit perm;
    logic [15:0] exp;
    fixed = (a < 6'd4);
    perm  = sup || (!fixed && !m_cfg[7]);
    exp   = 16'h0000;
    if (rd && !wr) begin
      if (perm)       exp = (a == 6'd0) ? m_cfg : m_mem[a];
      else if (fixed) exp = 16'h0000;
      else            exp = 16'hFFFF;
    end
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d; bus_super = sup;
    @(negedge clk);
    check(bus_ready === 1'b1, {tag, " ready"}, {15'd0, bus_ready}, 16'h0001);
    check(bus_rdata === exp, {tag, " rdata"}, bus_rdata, exp);
    if (wr && perm) begin
      if (a == 6'd0) m_cfg = d;
      else           m_mem[a] = d;
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input string tag);
    bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    check(bus_ready === 1'b0, {tag, " idle ready"}, {15'd0, bus_ready}, 16'h0000);
    check(bus_rdata === 16'h0000, {tag, " idle rdata"}, bus_rdata, 16'h0000);
  endtask

  task automatic t_reset();
    check(bus_ready === 1'b0, "R1 ready after reset", {15'd0, bus_ready}, 16'h0000);
    check(bus_rdata === 16'h0000, "R1 rdata after reset", bus_rdata, 16'h0000);
    do_access(1, 0, 1, 6'd0, 16'h0, "R1 cfg reset value");
    check(m_cfg === 16'h0080, "R1 model cfg", m_cfg, 16'h0080);
  endtask

  task automatic t_super_pass();
    do_access(0, 1, 1, 6'd1, 16'h1111, "R2 sup write fixed");
    do_access(0, 1, 1, 6'd20, 16'h2020, "R2 sup write assign");
    do_access(1, 0, 1, 6'd1, 16'h0, "R2 sup read fixed");
    do_access(1, 0, 1, 6'd20, 16'h0, "R2 sup read assign");
  endtask

  task automatic t_user_fixed();
    do_access(1, 0, 0, 6'd1, 16'h0, "R3 user read fixed");
    do_access(1, 0, 0, 6'd0, 16'h0, "R7 user read cfg");
    do_access(0, 1, 0, 6'd0, 16'h0000, "R7 user write cfg");
    do_access(1, 0, 1, 6'd0, 16'h0, "R7 cfg unchanged");
    do_access(0, 1, 0, 6'd1, 16'hDEAD, "R5 user write fixed");
    do_access(1, 0, 1, 6'd1, 16'h0, "R5 fixed unchanged");
  endtask

  task automatic t_user_assign_prot();
    do_access(1, 0, 0, 6'd20, 16'h0, "R4 user read protected");
    do_access(0, 1, 0, 6'd20, 16'hBEEF, "R5 user write protected");
    do_access(1, 0, 1, 6'd20, 16'h0, "R5 assign unchanged");
  endtask

  task automatic t_unrestricted();
    do_access(0, 1, 1, 6'd0, 16'h0000, "R6 open segment");
    do_access(0, 1, 0, 6'd33, 16'h3333, "R6 user write open");
    do_access(1, 0, 0, 6'd33, 16'h0, "R6 user read open");
    do_access(1, 0, 0, 6'd2, 16'h0, "R3 fixed still denied");
    do_access(0, 1, 0, 6'd0, 16'h0080, "R7 user cannot set cfg");
    do_access(1, 0, 1, 6'd0, 16'h0, "R7 cfg still open");
    do_access(0, 1, 1, 6'd0, 16'h0080, "R6 restore protection");
  endtask

  task automatic t_dual_strobe();
    do_access(1, 1, 1, 6'd40, 16'h4040, "R9 dual strobe");
    do_access(1, 0, 1, 6'd40, 16'h0, "R9 write landed");
  endtask

  task automatic t_supv_b2b();
    do_access(0, 1, 1, 6'd0, 16'h0000, "R10 clear bit");
    do_access(1, 0, 0, 6'd33, 16'h0, "R10 next-cycle open read");
    do_access(0, 1, 1, 6'd0, 16'h0080, "R10 set bit");
    do_access(1, 0, 0, 6'd33, 16'h0, "R10 next-cycle denied read");
    do_access(0, 1, 0, 6'd33, 16'h7777, "R10 next-cycle denied write");
    do_access(1, 0, 1, 6'd33, 16'h0, "R10 word kept");
  endtask

  task automatic t_ready_pattern();
    idle("R8");
    do_access(1, 0, 1, 6'd5, 16'h0, "R8 single read");
    idle("R8 after read");
    do_access(0, 1, 0, 6'd6, 16'h1, "R8 single write");
    idle("R8 after write");
  endtask

  task automatic t_sweep();
    logic [5:0] addrs [3];
    int n;
    addrs[0] = 6'd0; addrs[1] = 6'd3; addrs[2] = 6'd50;
    n = 0;
    for (int pv = 0; pv < 2; pv++) begin
      do_access(0, 1, 1, 6'd0, pv[0] ? 16'h0080 : 16'h0000, "R2 sweep set bit");
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 3; k++) begin
          if (addrs[k] != 6'd0) begin
            n++;
            do_access(0, 1, s[0], addrs[k], 16'hA000 + 16'(n), "R5 sweep write");
          end
          do_access(1, 0, s[0], addrs[k], 16'h0, "R6 sweep read");
          do_access(1, 0, 1, addrs[k], 16'h0, "R2 sweep readback");
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 16'h0000;
    m_cfg = 16'h0080;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_super_pass();
    t_user_fixed();
    t_user_assign_prot();
    t_unrestricted();
    t_dual_strobe();
    t_supv_b2b();
    t_ready_pattern();
    t_sweep();
    idle("R8 end");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule